// File: doc/BRIEF.md
# Integer Result Rename Buffer with In-Order Retirement

This block holds integer results between dispatch and architectural commit. Dispatch claims up to two entries per cycle from a twelve-entry circular queue and receives a tag for each. Execution units later post a result against a tag, along with exception and status flags. Retirement walks the queue from the oldest entry in program order. It presents at most two results per cycle on two register-file write ports, and it stops at the first entry whose result has not arrived.

When a retiring entry carries an exception, or belongs to a class of operations that must serialize the machine, every younger entry is discarded in a single cycle. The tail pointer is pulled back to just past the offending entry, and a one-cycle redirect pulse tells fetch to restart. Some classes always force this flush. Others force it only under conditions reported with the result: a summary-overflow update, an empty string load, or a floating-point invalid-operation or zero-divide event while the matching enable is set. The flush decision is made when the result is posted and stored with the entry, so retirement only reads one flag per entry.

Top module: `rename_retire_unit`

## Requirements
- R1: After reset the buffer is empty: `alloc_stall`, `wb_en0`, `wb_en1` and `redirect` are 0, and `alloc_tag0` is 0.
- R2: A dispatch of `alloc_cnt` entries (1 or 2; 3 is treated as 2) is granted tags in order. `alloc_tag0` is the current tail, and `alloc_tag1` is the tail plus one modulo 12. The tail advances by the granted count and wraps from 11 to 0.
- R3: `alloc_stall` is 1, and nothing is allocated, when the number of free entries (12 minus the occupancy at the start of the cycle) is below the requested count, or when a flush is being taken that cycle.
- R4: A posted result (`fin_valid`) is stored in the entry named by `fin_tag` only if that entry is allocated. A post to a free or squashed entry has no effect, and an entry allocated there later still waits for its own result.
- R5: Retirement is in program order. Port 0 carries the oldest entry, and port 1 carries the next one only if port 0 also retires that cycle. At most two entries leave per cycle. Nothing retires while the oldest entry is unfinished. The write ports show the state at the start of the cycle, and the entries are freed at the next clock edge.
- R6: An oldest-retiring entry with `fin_exc` set retires without a register write. All younger entries are discarded, and in the following cycle `redirect` and `redirect_exc` are both 1.
- R7: Class codes on `alloc_cls*` are: 0 plain, 1 write of the fixed-point exception register, 2 copy of that register's fields to the condition register, 3 instruction synchronize, 4 string load, 5 floating arithmetic/round-to-single/convert-to-integer, 6 other floating-point. Classes 1–3 always flush on retirement. Such an entry writes its result, discards younger entries, and raises `redirect` with `redirect_exc` 0 in the next cycle.
- R8: A flush is also forced in four cases: when the post has `fin_so_set` set, for any class; for class 4 with `fin_zero_len` set; for class 5 with `fin_fp_vx` and `fp_inv_en` both set; and for class 5 or 6 with `fin_fp_zx` and `fp_zdiv_en` both set. The enables are sampled when the result is posted. In every other case the entry retires normally.
- R9: If the older of two retiring entries flushes, the younger is squashed in the same cycle (`wb_en1` = 0). If only the younger flushes, both write.
- R10: After a flush the next granted tag is the index just past the flushing entry. `redirect` is high for exactly one cycle.
- R11: Occupancy never exceeds 12 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt | input | 2 | Number of entries requested by dispatch this cycle |
| alloc_rd0 | input | 5 | Destination register of the first new entry |
| alloc_cls0 | input | 3 | Class code of the first new entry |
| alloc_rd1 | input | 5 | Destination register of the second new entry |
| alloc_cls1 | input | 3 | Class code of the second new entry |
| alloc_stall | output | 1 | Request refused this cycle |
| alloc_tag0 | output | 4 | Tag granted to the first new entry |
| alloc_tag1 | output | 4 | Tag granted to the second new entry |
| fin_valid | input | 1 | Result post strobe |
| fin_tag | input | 4 | Entry the result belongs to |
| fin_data | input | 32 | Result value |
| fin_exc | input | 1 | Result carries exception status |
| fin_so_set | input | 1 | Operation set the summary-overflow bit |
| fin_zero_len | input | 1 | String load had a zero byte count |
| fin_fp_vx | input | 1 | Floating invalid-operation event |
| fin_fp_zx | input | 1 | Floating zero-divide event |
| fp_inv_en | input | 1 | Invalid-operation exception enable |
| fp_zdiv_en | input | 1 | Zero-divide exception enable |
| wb_en0 | output | 1 | Write port 0 enable |
| wb_rd0 | output | 5 | Write port 0 register index |
| wb_data0 | output | 32 | Write port 0 data |
| wb_en1 | output | 1 | Write port 1 enable |
| wb_rd1 | output | 5 | Write port 1 register index |
| wb_data1 | output | 32 | Write port 1 data |
| redirect | output | 1 | One-cycle fetch redirect pulse |
| redirect_exc | output | 1 | Redirect was caused by an exception |

## Verification
The bound checker watches several properties on every cycle. Port 1 never writes without port 0. A redirect lasts one cycle and always finds the buffer empty with no write pending. Occupancy stays within twelve. A refused dispatch never raises occupancy. The bench's directed scenarios cover what a cycle-local property cannot express. These are the tag sequence across the wrap, values and register indices leaving in program order after out-of-order posts, the class and enable combinations that do or do not flush, the squash of the younger partner when the older one flushes, and the first tag handed out after recovery.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic [2:0] {
        CLS_PLAIN    = 3'd0,
        CLS_XER_WR   = 3'd1,
        CLS_XER_CR   = 3'd2,
        CLS_SYNC     = 3'd3,
        CLS_STR_LD   = 3'd4,
        CLS_FP_ARITH = 3'd5,
        CLS_FP_OTHER = 3'd6
    } op_class_e;

endpackage

// File: rtl/rr_flush_decode.sv
module rr_flush_decode
    import rr_pkg::*;
(
    input  logic [2:0] cls,
    input  logic       so_set,
    input  logic       zero_len,
    input  logic       fp_vx,
    input  logic       fp_zx,
    input  logic       inv_en,
    input  logic       zdiv_en,
    output logic       force_flush
);
    op_class_e c;
    logic      always_ser;
    logic      fp_arith;
    logic      fp_any;

    always_comb begin
        c          = op_class_e'(cls);
        always_ser = (c == CLS_XER_WR) || (c == CLS_XER_CR) || (c == CLS_SYNC);
        fp_arith   = (c == CLS_FP_ARITH);
        fp_any     = fp_arith || (c == CLS_FP_OTHER);
        force_flush = always_ser
                    || so_set
                    || ((c == CLS_STR_LD) && zero_len)
                    || (fp_arith && fp_vx && inv_en)
                    || (fp_any && fp_zx && zdiv_en);
    end
endmodule

// File: rtl/rr_alloc_ctl.sv
module rr_alloc_ctl #(
    parameter int DEPTH = 12,
    parameter int TAG_W = 4,
    parameter int CNT_W = 4
) (
    input  logic [TAG_W-1:0] tail,
    input  logic [CNT_W-1:0] occ,
    input  logic [1:0]       req_cnt,
    input  logic             flush_now,
    output logic [1:0]       grant,
    output logic             stall,
    output logic [TAG_W-1:0] tag0,
    output logic [TAG_W-1:0] tag1,
    output logic [TAG_W-1:0] tail_nxt
);
    localparam logic [TAG_W:0]   DEPTH_V = (TAG_W+1)'(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    function automatic logic [TAG_W-1:0] adv(input logic [TAG_W-1:0] p, input logic [1:0] n);
        logic [TAG_W:0] s;
        s = {1'b0, p} + (TAG_W+1)'(n);
        if (s >= DEPTH_V) s = s - DEPTH_V;
        return s[TAG_W-1:0];
    endfunction

    logic [1:0]       req;
    logic [CNT_W-1:0] free_cnt;

    always_comb begin
        req      = (req_cnt > 2'd2) ? 2'd2 : req_cnt;
        free_cnt = DEPTH_C - occ;
        stall    = flush_now || (free_cnt < CNT_W'(req));
        grant    = stall ? 2'd0 : req;
        tag0     = tail;
        tag1     = adv(tail, 2'd1);
        tail_nxt = adv(tail, grant);
    end
endmodule

// File: rtl/rr_retire_sel.sv
module rr_retire_sel #(
    parameter int DEPTH = 12,
    parameter int TAG_W = 4
) (
    input  logic [TAG_W-1:0] head,
    input  logic [DEPTH-1:0] valid,
    input  logic [DEPTH-1:0] fin,
    input  logic [DEPTH-1:0] exc,
    input  logic [DEPTH-1:0] fcls,
    output logic [TAG_W-1:0] idx1,
    output logic             ret0,
    output logic             ret1,
    output logic             wr0,
    output logic             wr1,
    output logic             flush,
    output logic             flush_exc,
    output logic [TAG_W-1:0] head_nxt
);
    localparam logic [TAG_W:0] DEPTH_V = (TAG_W+1)'(DEPTH);

    function automatic logic [TAG_W-1:0] adv(input logic [TAG_W-1:0] p, input logic [1:0] n);
        logic [TAG_W:0] s;
        s = {1'b0, p} + (TAG_W+1)'(n);
        if (s >= DEPTH_V) s = s - DEPTH_V;
        return s[TAG_W-1:0];
    endfunction

    logic fl0;
    logic fl1;

    always_comb begin
        idx1      = adv(head, 2'd1);
        ret0      = valid[head] && fin[head];
        fl0       = ret0 && (exc[head] || fcls[head]);
        ret1      = ret0 && !fl0 && valid[idx1] && fin[idx1];
        fl1       = ret1 && (exc[idx1] || fcls[idx1]);
        flush     = fl0 || fl1;
        flush_exc = (fl0 && exc[head]) || (fl1 && exc[idx1]);
        wr0       = ret0 && !exc[head];
        wr1       = ret1 && !exc[idx1];
        head_nxt  = adv(head, 2'(ret0) + 2'(ret1));
    end
endmodule

// File: rtl/rename_retire_unit.sv
module rename_retire_unit #(
    parameter  int DEPTH  = 12,
    parameter  int DATA_W = 32,
    parameter  int RIDX_W = 5,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        alloc_cnt,
    input  logic [RIDX_W-1:0] alloc_rd0,
    input  logic [2:0]        alloc_cls0,
    input  logic [RIDX_W-1:0] alloc_rd1,
    input  logic [2:0]        alloc_cls1,
    output logic              alloc_stall,
    output logic [TAG_W-1:0]  alloc_tag0,
    output logic [TAG_W-1:0]  alloc_tag1,
    input  logic              fin_valid,
    input  logic [TAG_W-1:0]  fin_tag,
    input  logic [DATA_W-1:0] fin_data,
    input  logic              fin_exc,
    input  logic              fin_so_set,
    input  logic              fin_zero_len,
    input  logic              fin_fp_vx,
    input  logic              fin_fp_zx,
    input  logic              fp_inv_en,
    input  logic              fp_zdiv_en,
    output logic              wb_en0,
    output logic [RIDX_W-1:0] wb_rd0,
    output logic [DATA_W-1:0] wb_data0,
    output logic              wb_en1,
    output logic [RIDX_W-1:0] wb_rd1,
    output logic [DATA_W-1:0] wb_data1,
    output logic              redirect,
    output logic              redirect_exc
);
    typedef struct packed {
        logic [DEPTH-1:0]              valid;
        logic [DEPTH-1:0]              fin;
        logic [DEPTH-1:0]              exc;
        logic [DEPTH-1:0]              fcls;
        logic [DEPTH-1:0][2:0]         cls;
        logic [DEPTH-1:0][RIDX_W-1:0]  rd;
        logic [DEPTH-1:0][DATA_W-1:0]  data;
        logic [TAG_W-1:0]              head;
        logic [TAG_W-1:0]              tail;
        logic [CNT_W-1:0]              count;
        logic                          redir;
        logic                          redir_exc;
    } state_t;

    state_t s_q, s_d;

    logic [CNT_W-1:0] occ;
    logic             fin_hit;
    logic             force_flush;
    logic [1:0]       grant;
    logic [TAG_W-1:0] tail_nxt;
    logic [TAG_W-1:0] idx1;
    logic             ret0, ret1, wr0, wr1;
    logic             flush, flush_exc;
    logic [TAG_W-1:0] head_nxt;

    assign occ     = s_q.count;
    assign fin_hit = fin_valid && (fin_tag < TAG_W'(DEPTH)) && s_q.valid[fin_tag];

    rr_flush_decode u_dec (
        .cls         (s_q.cls[fin_tag]),
        .so_set      (fin_so_set),
        .zero_len    (fin_zero_len),
        .fp_vx       (fin_fp_vx),
        .fp_zx       (fin_fp_zx),
        .inv_en      (fp_inv_en),
        .zdiv_en     (fp_zdiv_en),
        .force_flush (force_flush)
    );

    rr_retire_sel #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ret (
        .head      (s_q.head),
        .valid     (s_q.valid),
        .fin       (s_q.fin),
        .exc       (s_q.exc),
        .fcls      (s_q.fcls),
        .idx1      (idx1),
        .ret0      (ret0),
        .ret1      (ret1),
        .wr0       (wr0),
        .wr1       (wr1),
        .flush     (flush),
        .flush_exc (flush_exc),
        .head_nxt  (head_nxt)
    );

    rr_alloc_ctl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_alloc (
        .tail      (s_q.tail),
        .occ       (occ),
        .req_cnt   (alloc_cnt),
        .flush_now (flush),
        .grant     (grant),
        .stall     (alloc_stall),
        .tag0      (alloc_tag0),
        .tag1      (alloc_tag1),
        .tail_nxt  (tail_nxt)
    );

    always_comb begin
        s_d = s_q;

        // result capture
        if (fin_hit) begin
            s_d.fin[fin_tag]  = 1'b1;
            s_d.exc[fin_tag]  = fin_exc;
            s_d.fcls[fin_tag] = force_flush;
            s_d.data[fin_tag] = fin_data;
        end

        // retirement frees entries from the head
        if (ret0) s_d.valid[s_q.head] = 1'b0;
        if (ret1) s_d.valid[idx1]     = 1'b0;
        s_d.head      = head_nxt;
        s_d.redir     = flush;
        s_d.redir_exc = flush_exc;

        if (flush) begin
            s_d.valid = '0;
            s_d.tail  = head_nxt;
            s_d.count = '0;
        end else begin
            if (grant != 2'd0) begin
                s_d.valid[alloc_tag0] = 1'b1;
                s_d.fin[alloc_tag0]   = 1'b0;
                s_d.exc[alloc_tag0]   = 1'b0;
                s_d.fcls[alloc_tag0]  = 1'b0;
                s_d.cls[alloc_tag0]   = alloc_cls0;
                s_d.rd[alloc_tag0]    = alloc_rd0;
            end
            if (grant == 2'd2) begin
                s_d.valid[alloc_tag1] = 1'b1;
                s_d.fin[alloc_tag1]   = 1'b0;
                s_d.exc[alloc_tag1]   = 1'b0;
                s_d.fcls[alloc_tag1]  = 1'b0;
                s_d.cls[alloc_tag1]   = alloc_cls1;
                s_d.rd[alloc_tag1]    = alloc_rd1;
            end
            s_d.tail  = tail_nxt;
            s_d.count = s_q.count - CNT_W'(2'(ret0) + 2'(ret1)) + CNT_W'(grant);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wb_en0       = wr0;
    assign wb_rd0       = s_q.rd[s_q.head];
    assign wb_data0     = s_q.data[s_q.head];
    assign wb_en1       = wr1;
    assign wb_rd1       = s_q.rd[idx1];
    assign wb_data1     = s_q.data[idx1];
    assign redirect     = s_q.redir;
    assign redirect_exc = s_q.redir_exc;
endmodule

// File: rtl/rename_retire_chk.sv
module rename_retire_chk #(
    parameter int DEPTH = 12,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_stall,
    input logic             wb_en0,
    input logic             wb_en1,
    input logic             redirect,
    input logic [CNT_W-1:0] occ
);
    // R5
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en1 |-> wb_en0);

    // R10
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    // R6
    squash_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (occ == '0 && !wb_en0));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |=> occ <= $past(occ));
endmodule

bind rename_retire_unit rename_retire_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_stall (alloc_stall),
    .wb_en0      (wb_en0),
    .wb_en1      (wb_en1),
    .redirect    (redirect),
    .occ         (occ)
);

// File: tb/rename_retire_unit_test.sv
module rename_retire_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 12;

    logic        clk = 0;
    logic        rst_n;
    logic [1:0]  alloc_cnt;
    logic [4:0]  alloc_rd0, alloc_rd1;
    logic [2:0]  alloc_cls0, alloc_cls1;
    logic        alloc_stall;
    logic [3:0]  alloc_tag0, alloc_tag1;
    logic        fin_valid;
    logic [3:0]  fin_tag;
    logic [31:0] fin_data;
    logic        fin_exc, fin_so_set, fin_zero_len, fin_fp_vx, fin_fp_zx;
    logic        fp_inv_en, fp_zdiv_en;
    logic        wb_en0, wb_en1;
    logic [4:0]  wb_rd0, wb_rd1;
    logic [31:0] wb_data0, wb_data1;
    logic        redirect, redirect_exc;

    int checks = 0;
    int fails  = 0;
    int etail  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_retire_unit uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_cnt(alloc_cnt), .alloc_rd0(alloc_rd0), .alloc_cls0(alloc_cls0),
        .alloc_rd1(alloc_rd1), .alloc_cls1(alloc_cls1),
        .alloc_stall(alloc_stall), .alloc_tag0(alloc_tag0), .alloc_tag1(alloc_tag1),
        .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_data(fin_data),
        .fin_exc(fin_exc), .fin_so_set(fin_so_set), .fin_zero_len(fin_zero_len),
        .fin_fp_vx(fin_fp_vx), .fin_fp_zx(fin_fp_zx),
        .fp_inv_en(fp_inv_en), .fp_zdiv_en(fp_zdiv_en),
        .wb_en0(wb_en0), .wb_rd0(wb_rd0), .wb_data0(wb_data0),
        .wb_en1(wb_en1), .wb_rd1(wb_rd1), .wb_data1(wb_data1),
        .redirect(redirect), .redirect_exc(redirect_exc)
    );

    task automatic check_eq(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        alloc_cnt = 0; alloc_rd0 = 0; alloc_rd1 = 0; alloc_cls0 = 0; alloc_cls1 = 0;
        fin_valid = 0; fin_tag = 0; fin_data = 0; fin_exc = 0; fin_so_set = 0;
        fin_zero_len = 0; fin_fp_vx = 0; fin_fp_zx = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1 clear_inputs();
        @(negedge clk);
    endtask

    task automatic do_alloc(int n, int rd0, int cls0, int rd1, int cls1);
        alloc_cnt = 2'(n); alloc_rd0 = 5'(rd0); alloc_cls0 = 3'(cls0);
        alloc_rd1 = 5'(rd1); alloc_cls1 = 3'(cls1);
        #1;
        check_eq("R3 stall on grantable request", alloc_stall, 0);
        check_eq("R2 first tag", alloc_tag0, etail);
        if (n == 2) check_eq("R2 second tag", alloc_tag1, (etail + 1) % DEPTH);
        step();
        etail = (etail + n) % DEPTH;
    endtask

    task automatic do_fin(int tag, logic [31:0] d, bit exc, bit so, bit zl, bit vx, bit zx);
        fin_valid = 1; fin_tag = 4'(tag); fin_data = d; fin_exc = exc;
        fin_so_set = so; fin_zero_len = zl; fin_fp_vx = vx; fin_fp_zx = zx;
        step();
    endtask

    task automatic t_reset();
        rst_n = 0;
        clear_inputs();
        fp_inv_en = 0; fp_zdiv_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check_eq("R1 stall after reset", alloc_stall, 0);
        check_eq("R1 port0 idle", wb_en0, 0);
        check_eq("R1 port1 idle", wb_en1, 0);
        check_eq("R1 no redirect", redirect, 0);
        check_eq("R1 first tag zero", alloc_tag0, 0);
        @(negedge clk);
    endtask

    task automatic t_basic();
        int t0 = etail;
        do_alloc(2, 3, 0, 4, 0);
        do_fin((t0 + 1) % DEPTH, 32'h0000_00BB, 0, 0, 0, 0, 0);
        check_eq("R5 blocked by unfinished head", wb_en0, 0);
        do_fin(t0, 32'h0000_00AA, 0, 0, 0, 0, 0);
        check_eq("R5 port0 enable", wb_en0, 1);
        check_eq("R5 port0 reg", wb_rd0, 3);
        check_eq("R5 port0 data", wb_data0, 32'hAA);
        check_eq("R5 port1 enable", wb_en1, 1);
        check_eq("R5 port1 reg", wb_rd1, 4);
        check_eq("R5 port1 data", wb_data1, 32'hBB);
        step();
        check_eq("R5 empty after retire", wb_en0, 0);
        // R4: post to a free entry, then allocate that entry
        do_fin(etail, 32'hDEAD, 0, 0, 0, 0, 0);
        do_alloc(1, 9, 0, 0, 0);
        check_eq("R4 stale post ignored", wb_en0, 0);
        do_fin((etail + DEPTH - 1) % DEPTH, 32'h1234, 0, 0, 0, 0, 0);
        check_eq("R4 own post retires", wb_en0, 1);
        check_eq("R4 own post data", wb_data0, 32'h1234);
        step();
    endtask

    task automatic t_full();
        int base = etail;
        for (int k = 0; k < 5; k++) do_alloc(2, 2*k, 0, 2*k + 1, 0);
        do_alloc(1, 10, 0, 0, 0);
        alloc_cnt = 2; #1;
        check_eq("R3 stall with one free and two asked", alloc_stall, 1);
        step();
        do_alloc(1, 11, 0, 0, 0);
        alloc_cnt = 1; #1;
        check_eq("R3 stall when full", alloc_stall, 1);
        step();
        for (int i = 11; i >= 0; i--) do_fin((base + i) % DEPTH, 32'h100 + i, 0, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) begin
            check_eq("R5 pair port0 enable", wb_en0, 1);
            check_eq("R5 pair port0 reg", wb_rd0, 2*k);
            check_eq("R5 pair port0 data", wb_data0, 32'h100 + 2*k);
            check_eq("R5 pair port1 enable", wb_en1, 1);
            check_eq("R5 pair port1 reg", wb_rd1, 2*k + 1);
            step();
        end
        check_eq("R5 drained", wb_en0, 0);
    endtask

    task automatic t_exc();
        int t0 = etail;
        do_alloc(2, 7, 0, 8, 0);
        do_fin((t0 + 1) % DEPTH, 32'h88, 0, 0, 0, 0, 0);
        do_fin(t0, 32'h77, 1, 0, 0, 0, 0);
        check_eq("R6 no write for excepting entry", wb_en0, 0);
        check_eq("R6 younger not written", wb_en1, 0);
        alloc_cnt = 1; #1;
        check_eq("R3 stall in flush cycle", alloc_stall, 1);
        step();
        check_eq("R6 redirect", redirect, 1);
        check_eq("R6 redirect cause exception", redirect_exc, 1);
        check_eq("R6 younger squashed", wb_en0, 0);
        etail = (t0 + 1) % DEPTH;
        step();
        check_eq("R10 redirect one cycle", redirect, 0);
        do_alloc(1, 12, 0, 0, 0);
        do_fin((t0 + 1) % DEPTH, 32'h99, 0, 0, 0, 0, 0);
        check_eq("R10 reused entry retires", wb_en0, 1);
        check_eq("R10 reused entry data", wb_data0, 32'h99);
        step();
    endtask

    task automatic run_single(string req, int cls, bit so, bit zl, bit vx, bit zx,
                              bit ve, bit ze, bit exp_flush);
        int t0 = etail;
        do_alloc(2, 10, cls, 11, 0);
        fp_inv_en = ve; fp_zdiv_en = ze;
        do_fin((t0 + 1) % DEPTH, 32'h11, 0, 0, 0, 0, 0);
        do_fin(t0, 32'h10, 0, so, zl, vx, zx);
        fp_inv_en = 0; fp_zdiv_en = 0;
        check_eq({req, " older writes"}, wb_en0, 1);
        check_eq({req, " older reg"}, wb_rd0, 10);
        check_eq({req, " younger write (R9)"}, wb_en1, !exp_flush);
        step();
        check_eq({req, " redirect"}, redirect, exp_flush);
        if (exp_flush) begin
            check_eq({req, " redirect cause"}, redirect_exc, 0);
            etail = (t0 + 1) % DEPTH;
        end else begin
            etail = (t0 + 2) % DEPTH;
        end
        step();
    endtask

    task automatic t_young_flush();
        int t0 = etail;
        do_alloc(2, 1, 0, 2, 3);
        do_alloc(1, 3, 0, 0, 0);
        do_fin((t0 + 2) % DEPTH, 32'h3, 0, 0, 0, 0, 0);
        do_fin((t0 + 1) % DEPTH, 32'h2, 0, 0, 0, 0, 0);
        do_fin(t0, 32'h1, 0, 0, 0, 0, 0);
        check_eq("R9 both write when younger flushes", wb_en0 & wb_en1, 1);
        step();
        check_eq("R9 redirect from younger", redirect, 1);
        check_eq("R9 third entry squashed", wb_en0, 0);
        etail = (t0 + 2) % DEPTH;
        step();
        do_alloc(1, 4, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_full();
        t_exc();
        run_single("R8 plain no flags",          0, 0, 0, 0, 0, 0, 0, 0);
        run_single("R7 exception reg write",     1, 0, 0, 0, 0, 0, 0, 1);
        run_single("R7 exception reg to cr",     2, 0, 0, 0, 0, 0, 0, 1);
        run_single("R7 synchronize",             3, 0, 0, 0, 0, 0, 0, 1);
        run_single("R8 summary overflow",        0, 1, 0, 0, 0, 0, 0, 1);
        run_single("R8 empty string load",       4, 0, 1, 0, 0, 0, 0, 1);
        run_single("R8 nonempty string load",    4, 0, 0, 0, 0, 0, 0, 0);
        run_single("R8 fp invalid disabled",     5, 0, 0, 1, 0, 0, 0, 0);
        run_single("R8 fp invalid enabled",      5, 0, 0, 1, 0, 1, 0, 1);
        run_single("R8 other fp invalid",        6, 0, 0, 1, 0, 1, 0, 0);
        run_single("R8 fp zero divide enabled",  6, 0, 0, 0, 1, 0, 1, 1);
        run_single("R8 fp zero divide disabled", 5, 0, 0, 0, 1, 0, 0, 0);
        run_single("R8 zero divide on plain",    0, 0, 0, 0, 1, 0, 1, 0);
        t_young_flush();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule